// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

The engine paints an axis-aligned rectangle of frame memory with a single pixel value. A one-cycle `start` pulse captures the whole command: the mix word carrying the raster-operation code, the destination corner, width and height, the two direction flags, the choice between the destination or default pitch/offset pair, the pixel datatype, the brush foreground colour and two 24-bit palette colours. From then on the command is held inside the block, so the driving registers may change while the fill runs.

After one cycle of validation the engine issues one memory write per pixel on a request/ready port. Each write carries a byte address, a 32-bit little-endian data word and a byte-enable mask that covers 1 to 4 bytes. When the last pixel is accepted, the engine pulses `done` and presents the updated destination Y. An invalid command ends with an `errFlag` pulse. An unsupported operation code ends with an `unimpFlag` pulse. In both cases nothing is written.

Top module: `rectFill`

## Requirements
- R1: The operation code is `mixReg[23:16]`. Code 0xF0 fills with `brushColor`, 0x00 fills with the black value and 0xFF fills with the white value.
- R2: The black value is `{8'hFF, palBlack}` and the white value is `{8'hFF, palWhite}`. Each palette input is packed with red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: Any other operation code on a valid command produces no write, no `done` and a one-cycle `unimpFlag` pulse.
- R4: `dataType[3:0]` gives the bytes per pixel: 2 gives 1, 3 or 4 give 2, 5 gives 3 and 6 gives 4. The write carries `memBe` with the low bytes-per-pixel bits set and `memData` equal to the fill value with the unused lanes zeroed. Byte lane 0 (bits 7:0) belongs at `memAddr`.
- R5: The start X is `dstX` when `dirLeftToRight` is 1, otherwise `dstX + 1 - rectW`. The start Y is `dstY` when `dirTopToBottom` is 1, otherwise `dstY + 1 - rectH`. Both are computed modulo 2^32.
- R6: Writes run row by row from the start Y upward in address, and left to right within a row, whatever the direction flags are. Each address is base + (startY+row)*pitch + (startX+col)*bpp. The base and pitch come from `dstOffset`/`dstPitch` when `useDstRegs` is 1, otherwise from `defOffset`/`defPitch`.
- R7: On completion `done` pulses for one cycle. While it is high, `newDstY` equals start Y + height when `dirTopToBottom` is 1, otherwise start Y.
- R8: The command is rejected with a one-cycle `errFlag` pulse and no writes in any of these cases:
  - the datatype is not listed in R4;
  - the pitch is zero;
  - start X or start Y exceeds 0x3FFF;
  - the base is at or beyond MEM_BYTES;
  - base + startX*bpp + (startY+height)*pitch is at or beyond MEM_BYTES.
  These checks take precedence over R3.
- R9: While `memReq` is high and `memReady` is low, `memReq`, `memAddr`, `memData` and `memBe` hold steady.
- R10: The fill value is fixed at `start`. Later changes to the colour inputs do not alter the writes.
- R11: A valid command with zero width or zero height writes nothing and still completes as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture command and begin |
| mixReg | input | 32 | Mix word, operation code in bits 23:16 |
| dirLeftToRight | input | 1 | X direction flag |
| dirTopToBottom | input | 1 | Y direction flag |
| useDstRegs | input | 1 | Select destination pitch/offset over defaults |
| dataType | input | 4 | Pixel datatype code |
| dstX | input | 16 | Destination X |
| dstY | input | 16 | Destination Y |
| rectW | input | 16 | Width in pixels |
| rectH | input | 16 | Height in rows |
| dstPitch | input | 14 | Destination pitch in bytes |
| dstOffset | input | 24 | Destination base byte address |
| defPitch | input | 14 | Default pitch in bytes |
| defOffset | input | 24 | Default base byte address |
| brushColor | input | 32 | Brush foreground colour |
| palBlack | input | 24 | Palette colour for the black code |
| palWhite | input | 24 | Palette colour for the white code |
| memReq | output | 1 | Write request |
| memAddr | output | 24 | Byte address of the pixel |
| memData | output | 32 | Pixel data, little-endian lanes |
| memBe | output | 4 | Byte enables |
| memReady | input | 1 | Memory accepts the write |
| busy | output | 1 | Command in progress |
| done | output | 1 | Fill completed pulse |
| unimpFlag | output | 1 | Unsupported operation pulse |
| errFlag | output | 1 | Rejected command pulse |
| newDstY | output | 16 | Updated destination Y, valid with done |

## Verification
The assertions assume that `start` arrives only while `busy` is low. They also assume that `memReady` may drop at any cycle, but the memory never accepts a write that was not requested. The stimulus pulses `start` only after the previous command has reported an outcome. It drives `memReady` one time unit after each rising edge, in both stalling and always-ready patterns. Every command's geometry is picked so that it either fits inside MEM_BYTES or deliberately violates exactly the bound under test.

// File: rtl/rectFillPkg.sv
package rectFillPkg;
  localparam logic [7:0] OP_BRUSH = 8'hF0;
  localparam logic [7:0] OP_BLACK = 8'h00;
  localparam logic [7:0] OP_WHITE = 8'hFF;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_RUN, S_FIN} fillState_t;

  typedef struct packed {
    logic load;
    logic step;
  } fillStrobe_t;

  function automatic logic [2:0] bytesPerPixel(input logic [3:0] dt);
    case (dt)
      4'd2:       return 3'd1;
      4'd3, 4'd4: return 3'd2;
      4'd5:       return 3'd3;
      4'd6:       return 3'd4;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rectFillDp.sv
module rectFillDp
  import rectFillPkg::*;
#(
  parameter int COORD_W   = 16,
  parameter int PITCH_W   = 14,
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 1 << 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  fillStrobe_t        strb,
  input  logic [31:0]        mixReg,
  input  logic               dirLeftToRight,
  input  logic               dirTopToBottom,
  input  logic               useDstRegs,
  input  logic [3:0]         dataType,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [COORD_W-1:0] rectW,
  input  logic [COORD_W-1:0] rectH,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [ADDR_W-1:0]  dstOffset,
  input  logic [PITCH_W-1:0] defPitch,
  input  logic [ADDR_W-1:0]  defOffset,
  input  logic [31:0]        brushColor,
  input  logic [23:0]        palBlack,
  input  logic [23:0]        palWhite,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memData,
  output logic [3:0]         memBe,
  output logic               cmdBad,
  output logic               cmdUnimp,
  output logic               cmdEmpty,
  output logic               lastPix,
  output logic [COORD_W-1:0] newDstY
);
  localparam int CALC_W = 48;
  localparam int LIMIT  = 16'h3FFF;

  logic [CALC_W-1:0]  sxQ, syQ, baseQ, pitchQ;
  logic [COORD_W-1:0] wQ, hQ, rowQ, colQ;
  logic [2:0]         bppQ;
  logic [31:0]        fillQ;
  logic               opOkQ, ttbQ;

  logic [CALC_W-1:0] sxNext, syNext, bppWide, pixAddr, spanEnd;
  logic [31:0]       fillNext;
  logic              opOkNext;

  always_comb begin
    sxNext = dirLeftToRight ? CALC_W'(dstX)
                            : 32'(CALC_W'(dstX) + 1 - CALC_W'(rectW));
    syNext = dirTopToBottom ? CALC_W'(dstY)
                            : 32'(CALC_W'(dstY) + 1 - CALC_W'(rectH));
    opOkNext = 1'b1;
    case (mixReg[23:16])
      OP_BRUSH: fillNext = brushColor;
      OP_BLACK: fillNext = {8'hFF, palBlack};
      OP_WHITE: fillNext = {8'hFF, palWhite};
      default: begin
        fillNext = 32'd0;
        opOkNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sxQ <= '0; syQ <= '0; baseQ <= '0; pitchQ <= '0;
      wQ <= '0; hQ <= '0; rowQ <= '0; colQ <= '0;
      bppQ <= '0; fillQ <= '0; opOkQ <= 1'b0; ttbQ <= 1'b0;
    end else if (strb.load) begin
      sxQ    <= sxNext;
      syQ    <= syNext;
      baseQ  <= CALC_W'(useDstRegs ? dstOffset : defOffset);
      pitchQ <= CALC_W'(useDstRegs ? dstPitch : defPitch);
      wQ     <= rectW;
      hQ     <= rectH;
      bppQ   <= bytesPerPixel(dataType);
      fillQ  <= fillNext;
      opOkQ  <= opOkNext;
      ttbQ   <= dirTopToBottom;
      rowQ   <= '0;
      colQ   <= '0;
    end else if (strb.step) begin
      if (colQ == wQ - 1'b1) begin
        colQ <= '0;
        rowQ <= rowQ + 1'b1;
      end else begin
        colQ <= colQ + 1'b1;
      end
    end
  end

  always_comb begin
    bppWide = CALC_W'(bppQ);
    pixAddr = baseQ + (syQ + CALC_W'(rowQ)) * pitchQ + (sxQ + CALC_W'(colQ)) * bppWide;
    spanEnd = baseQ + sxQ * bppWide + (syQ + CALC_W'(hQ)) * pitchQ;
    cmdBad  = (bppQ == 3'd0) || (pitchQ == '0) ||
              (sxQ > CALC_W'(LIMIT)) || (syQ > CALC_W'(LIMIT)) ||
              (baseQ >= CALC_W'(MEM_BYTES)) || (spanEnd >= CALC_W'(MEM_BYTES));
    cmdUnimp = !opOkQ;
    cmdEmpty = (wQ == '0) || (hQ == '0);
    lastPix  = (colQ == wQ - 1'b1) && (rowQ == hQ - 1'b1);
    memAddr  = pixAddr[ADDR_W-1:0];
    newDstY  = ttbQ ? COORD_W'(syQ + CALC_W'(hQ)) : COORD_W'(syQ);
  end

  for (genvar lane = 0; lane < 4; lane++) begin : gLane
    assign memBe[lane] = (3'(lane) < bppQ);
    assign memData[lane*8 +: 8] = memBe[lane] ? fillQ[lane*8 +: 8] : 8'h00;
  end

  assert_be_low_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bppQ != 3'd0) |-> (memBe[0] && $countones(memBe) == int'(bppQ)));
endmodule

// File: rtl/rectFillCtrl.sv
module rectFillCtrl
  import rectFillPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cmdBad,
  input  logic        cmdUnimp,
  input  logic        cmdEmpty,
  input  logic        lastPix,
  input  logic        memReady,
  output fillStrobe_t strb,
  output logic        memReq,
  output logic        busy,
  output logic        done,
  output logic        unimpFlag,
  output logic        errFlag
);
  fillState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      S_IDLE: if (start) begin
        strb.load = 1'b1;
        stateNext = S_CHECK;
      end
      S_CHECK: begin
        if (cmdBad || cmdUnimp) stateNext = S_IDLE;
        else if (cmdEmpty)      stateNext = S_FIN;
        else                    stateNext = S_RUN;
      end
      S_RUN: if (memReady) begin
        if (lastPix) stateNext = S_FIN;
        else         strb.step = 1'b1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign memReq    = (state == S_RUN);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign errFlag   = (state == S_CHECK) && cmdBad;
  assign unimpFlag = (state == S_CHECK) && !cmdBad && cmdUnimp;

  assert_single_outcome_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, errFlag, unimpFlag}));
  assert_no_write_after_unimp_R3: assert property (@(posedge clk) disable iff (!rstN)
    unimpFlag |=> !memReq);
  assert_no_write_after_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !memReq);
endmodule

// File: rtl/rectFill.sv
module rectFill
  import rectFillPkg::*;
#(
  parameter int COORD_W   = 16,
  parameter int PITCH_W   = 14,
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 1 << 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [31:0]        mixReg,
  input  logic               dirLeftToRight,
  input  logic               dirTopToBottom,
  input  logic               useDstRegs,
  input  logic [3:0]         dataType,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [COORD_W-1:0] rectW,
  input  logic [COORD_W-1:0] rectH,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [ADDR_W-1:0]  dstOffset,
  input  logic [PITCH_W-1:0] defPitch,
  input  logic [ADDR_W-1:0]  defOffset,
  input  logic [31:0]        brushColor,
  input  logic [23:0]        palBlack,
  input  logic [23:0]        palWhite,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memData,
  output logic [3:0]         memBe,
  input  logic               memReady,
  output logic               busy,
  output logic               done,
  output logic               unimpFlag,
  output logic               errFlag,
  output logic [COORD_W-1:0] newDstY
);
  fillStrobe_t strb;
  logic cmdBad, cmdUnimp, cmdEmpty, lastPix;

  rectFillCtrl ctrl_i (
    .clk, .rstN, .start, .cmdBad, .cmdUnimp, .cmdEmpty, .lastPix, .memReady,
    .strb, .memReq, .busy, .done, .unimpFlag, .errFlag
  );

  rectFillDp #(
    .COORD_W(COORD_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)
  ) dp_i (
    .clk, .rstN, .strb, .mixReg, .dirLeftToRight, .dirTopToBottom, .useDstRegs,
    .dataType, .dstX, .dstY, .rectW, .rectH, .dstPitch, .dstOffset, .defPitch,
    .defOffset, .brushColor, .palBlack, .palWhite, .memAddr, .memData, .memBe,
    .cmdBad, .cmdUnimp, .cmdEmpty, .lastPix, .newDstY
  );

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memData) && $stable(memBe)));
  assert_write_in_memory_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (32'(memAddr) + 32'($countones(memBe)) <= 32'(MEM_BYTES)));
endmodule

// File: tb/rectFill_tb_top.sv
module rectFill_tb_top;
  localparam int MEM_BYTES = 1 << 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] mixReg = '0;
  logic dirLeftToRight = 1'b1, dirTopToBottom = 1'b1, useDstRegs = 1'b1;
  logic [3:0] dataType = 4'd6;
  logic [15:0] dstX = '0, dstY = '0, rectW = '0, rectH = '0;
  logic [13:0] dstPitch = 14'd256, defPitch = 14'd512;
  logic [23:0] dstOffset = 24'h001000, defOffset = 24'h020000;
  logic [31:0] brushColor = 32'h11223344;
  logic [23:0] palBlack = 24'h0A0B0C, palWhite = 24'hF1F2F3;
  logic memReq, memReady = 1'b1;
  logic [23:0] memAddr;
  logic [31:0] memData;
  logic [3:0] memBe;
  logic busy, done, unimpFlag, errFlag;
  logic [15:0] newDstY;

  int checks = 0, fails = 0;
  bit stallMode = 1'b0;
  int cyc = 0;

  typedef struct packed {
    logic [23:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
  } wr_t;
  wr_t expQ[$];

  always #10 clk = ~clk;

  rectFill dut_i (.*);

  // Ready pattern changes just after each rising edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 memReady = stallMode ? cyc[0] : 1'b1;
  end

  // Monitor: pop one expected write per accepted request.
  always @(negedge clk) begin
    if (rstN && memReq && memReady) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected write addr=%h data=%h be=%h expected none",
                 memAddr, memData, memBe);
      end else begin
        wr_t e;
        e = expQ.pop_front();
        if (memAddr !== e.addr || memData !== e.data || memBe !== e.be) begin
          fails++;
          $display("FAIL R6/R4 write got addr=%h data=%h be=%h expected addr=%h data=%h be=%h",
                   memAddr, memData, memBe, e.addr, e.data, e.be);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int bppOf(input logic [3:0] dt);
    case (dt)
      2: return 1;
      3, 4: return 2;
      5: return 3;
      6: return 4;
      default: return 0;
    endcase
  endfunction

  // kind: 0 = done, 1 = error, 2 = unimplemented
  task automatic runOp(input logic [7:0] op, input bit ltr, input bit ttb, input bit selDst,
                       input logic [3:0] dt, input int x, input int y, input int w, input int h,
                       input int kind, input bit changeColor, input string tag);
    int bpp, sx, sy, base, pitch, expY, got;
    logic [31:0] fill;
    bpp = bppOf(dt);
    sx = ltr ? x : x + 1 - w;
    sy = ttb ? y : y + 1 - h;
    base = selDst ? int'(dstOffset) : int'(defOffset);
    pitch = selDst ? int'(dstPitch) : int'(defPitch);
    fill = (op == 8'hF0) ? brushColor :
           (op == 8'h00) ? {8'hFF, palBlack} : {8'hFF, palWhite};
    expY = ttb ? sy + h : sy;
    if (kind == 0) begin
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          wr_t e;
          logic [31:0] d;
          logic [3:0] b;
          d = '0;
          b = '0;
          for (int k = 0; k < bpp; k++) begin
            d[k*8 +: 8] = fill[k*8 +: 8];
            b[k] = 1'b1;
          end
          e.addr = 24'(base + (sy + r) * pitch + (sx + c) * bpp);
          e.data = d;
          e.be = b;
          expQ.push_back(e);
        end
    end
    @(posedge clk); #2;
    mixReg = {8'h5A, op, 16'hA5C3};
    dirLeftToRight = ltr; dirTopToBottom = ttb; useDstRegs = selDst; dataType = dt;
    dstX = 16'(x); dstY = 16'(y); rectW = 16'(w); rectH = 16'(h);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (changeColor) begin
      brushColor = ~brushColor; palBlack = ~palBlack; palWhite = ~palWhite;
    end
    got = -1;
    while (got < 0) begin
      @(negedge clk);
      if (done) begin
        got = 0;
        check(newDstY == 16'(expY), {tag, " newDstY"}, newDstY, 16'(expY));
      end else if (errFlag) got = 1;
      else if (unimpFlag) got = 2;
    end
    check(got == kind, {tag, " outcome"}, got, kind);
    check(expQ.size() == 0, {tag, " pending writes"}, expQ.size(), 0);
    expQ.delete();
    if (changeColor) begin
      brushColor = ~brushColor; palBlack = ~palBlack; palWhite = ~palWhite;
    end
    @(negedge clk);
    check(!busy && !memReq, {tag, " idle after"}, {busy, memReq}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq && !done && !errFlag && !unimpFlag, "reset state",
          {busy, memReq, done, errFlag, unimpFlag}, 0);

    runOp(8'hF0, 1, 1, 1, 4'd6, 5, 7, 3, 2, 0, 0, "R1 brush 4B");
    stallMode = 1'b1;
    runOp(8'hF0, 1, 1, 1, 4'd6, 2, 3, 4, 2, 0, 0, "R9 stalled brush");
    runOp(8'h00, 0, 0, 0, 4'd2, 20, 30, 3, 4, 0, 0, "R5 R2 black reversed");
    runOp(8'hFF, 0, 1, 1, 4'd5, 10, 1, 2, 3, 0, 0, "R2 white 3B");
    runOp(8'hF0, 1, 0, 1, 4'd4, 8, 9, 5, 3, 0, 1, "R10 color change 2B");
    runOp(8'h00, 1, 1, 0, 4'd3, 0, 0, 2, 2, 0, 1, "R10 R4 black 2B");
    stallMode = 1'b0;
    runOp(8'hCC, 1, 1, 1, 4'd6, 1, 1, 2, 2, 2, 0, "R3 unsupported op");
    runOp(8'h01, 1, 1, 1, 4'd2, 1, 1, 1, 1, 2, 0, "R3 unsupported op 01");
    runOp(8'hF0, 1, 1, 1, 4'd7, 1, 1, 2, 2, 1, 0, "R8 R4 bad datatype");
    dstPitch = 14'd0;
    runOp(8'hF0, 1, 1, 1, 4'd6, 1, 1, 2, 2, 1, 0, "R8 zero pitch");
    runOp(8'hCC, 1, 1, 1, 4'd6, 1, 1, 2, 2, 1, 0, "R8 error before unimp");
    dstPitch = 14'd256;
    runOp(8'hF0, 1, 1, 1, 4'd2, 16'h4000, 1, 2, 2, 1, 0, "R8 x over limit");
    runOp(8'hF0, 0, 1, 1, 4'd2, 1, 1, 5, 2, 1, 0, "R8 R5 wrapped start x");
    runOp(8'hF0, 1, 1, 1, 4'd2, 16'h3FFF, 0, 1, 1, 0, 0, "R8 x at limit");
    dstOffset = 24'h0FFF00;
    runOp(8'hF0, 1, 1, 1, 4'd6, 0, 10, 2, 5, 1, 0, "R8 memory overrun");
    dstOffset = 24'h100000;
    runOp(8'hF0, 1, 1, 1, 4'd6, 0, 0, 1, 1, 1, 0, "R8 base beyond memory");
    dstOffset = 24'h001000;
    runOp(8'hF0, 1, 1, 1, 4'd6, 3, 4, 0, 3, 0, 0, "R11 zero width");
    runOp(8'hFF, 1, 0, 1, 4'd6, 3, 9, 2, 0, 0, 0, "R11 R7 zero height");
    runOp(8'hF0, 1, 0, 1, 4'd6, 6, 12, 2, 3, 0, 0, "R7 bottom-up y");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule